// File: doc/BRIEF.md
# BCD Watchdog Countdown with Interrupt Routing

This block is a watchdog timer whose period is held as four BCD digits split over two byte registers: the low byte holds hundredths of a second and the high byte holds whole seconds, for a range of 00.01 to 99.99 s. A one-cycle `tick` enable, expected at 100 Hz, drives a BCD down-counter. When the count runs out, the block raises the watchdog flag and reloads the period, so the alarm repeats if the host stays away. Any host access to either period register, read or write, restarts the count from the stored period and clears the alarm. A period of zero turns the watchdog off.

A control byte sets a mask for each alarm, a pulse-or-level mode shared by both interrupt pins, and a swap bit. The swap bit chooses which of the two active-low interrupt pins carries the watchdog alarm and which carries the time-of-day alarm. The time-of-day alarm comes from a neighbouring block as a set strobe and a clear strobe. Its flag is latched and routed here in the same way as the watchdog flag.

Host access is a synchronous register port. An access with `bus_cs` high and `bus_we` low is a read, and its data appears on `bus_rdata` one clock later.

Top module: `wdt_bcd_top`

## Requirements
- R1: The period registers at address 0xC (hundredths) and 0xD (seconds) each store the byte last written, and a read returns that byte.
- R2: With the period set to S seconds and H hundredths, the watchdog flag sets on the (100*S + H)-th tick after the last period access. The hundredths digits borrow into the seconds digits, and every counter digit stays in 0..9.
- R3: Without host access, the count reloads when the alarm fires, and the next alarm follows after the same number of ticks.
- R4: A read or a write of address 0xC or 0xD clears the watchdog flag and its interrupt, and restarts the count from the full period.
- R5: A write to only one period register takes effect on that access, combined with the current value of the other register.
- R6: While both period registers hold zero, no watchdog alarm occurs.
- R7: In the control register at 0xB, bit 1 reads the watchdog flag and bit 0 reads the time-of-day flag. Both bits ignore writes. Bits 7..2 read back as written.
- R8: Control bit 3 set to 1 keeps the watchdog interrupt inactive, but the flag still sets. Control bit 2 does the same for the time-of-day alarm.
- R9: With control bit 6 at 0, `int_a_n` carries the watchdog alarm and `int_b_n` carries the time-of-day alarm. With bit 6 at 1, the two pins swap.
- R10: With control bit 4 at 1 (pulse mode), each alarm drives its pin low for exactly PULSE_CYCLES clocks, then releases the pin and clears the flag.
- R11: With control bit 4 at 0 (level mode), an alarm stays asserted through later reloads until the host accesses 0xC or 0xD.
- R12: After reset, both interrupt pins are high and all registers read 0x00, so the watchdog starts disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Countdown enable, one clock wide, nominally 100 Hz |
| bus_cs | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after a read |
| tod_hit | input | 1 | Time-of-day alarm set strobe |
| tod_clr | input | 1 | Time-of-day alarm clear strobe |
| int_a_n | output | 1 | Active-low interrupt pin A |
| int_b_n | output | 1 | Active-low interrupt pin B |

## Verification
An access at a clock edge clears the watchdog flag at that edge. The pin releases one edge later. Read data is due one edge after the read. A final tick sets the flag at its edge, and the pin falls on the following edge.

The bench drives inputs on falling edges. It samples a pin only on the falling edge after the second register edge, and it samples read data on the falling edge right after the access. The tick count to the first low pin is compared with 100*S + H, computed from the BCD digits, across a sweep of small periods, carry boundaries and 99.99 s.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BYTE_W    = 8;
  localparam int BCD_DIGITS = 4;
  // control register bit positions (decoded by the routing and latches)
  localparam int CMD_SWAP  = 6;
  localparam int CMD_PULSE = 4;
  localparam int CMD_WMASK = 3;
  localparam int CMD_TMASK = 2;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/wdt_bcd_down.sv
module wdt_bcd_down #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                tick,
  input  logic [4*DIGITS-1:0] reload_val,
  output logic                hit,
  output logic [4*DIGITS-1:0] count
);
  localparam int W = 4 * DIGITS;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]      nxt;
  logic [DIGITS-1:0] borrow;
  logic              enabled;
  logic              at_one;

  assign borrow[0] = 1'b1;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      logic [3:0] cur;
      assign cur = count[4*d +: 4];
      assign nxt[4*d +: 4] = borrow[d] ? ((cur == 4'd0) ? 4'd9 : cur - 4'd1) : cur;
      if (d < DIGITS - 1) begin : g_chain
        assign borrow[d+1] = borrow[d] && (cur == 4'd0);
      end
    end
  endgenerate

  assign enabled = |reload_val;
  assign at_one  = (count == ONE);
  assign hit     = tick && enabled && at_one && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= reload_val;
    end else if (tick && enabled) begin
      count <= at_one ? reload_val : nxt;
    end
  end
endmodule

// File: rtl/wdt_alarm_latch.sv
module wdt_alarm_latch #(
  parameter int PULSE_CYCLES = 600000
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic pulse_mode,
  output logic flag
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSE_CYCLES);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag <= 1'b0;
      left <= '0;
    end else if (set) begin
      flag <= 1'b1;
      left <= FULL;
    end else if (flag && pulse_mode) begin
      if (left <= 1) begin
        flag <= 1'b0;
        left <= '0;
      end else begin
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_irq_route.sv
module wdt_irq_route (
  input  logic clk,
  input  logic rst,
  input  logic wd_act,
  input  logic tod_act,
  input  logic swap,
  output logic int_a_n,
  output logic int_b_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      int_a_n <= 1'b1;
      int_b_n <= 1'b1;
    end else begin
      int_a_n <= ~(swap ? tod_act : wd_act);
      int_b_n <= ~(swap ? wd_act : tod_act);
    end
  end
endmodule

// File: rtl/wdt_bcd_top.sv
module wdt_bcd_top
  import wdt_pkg::*;
#(
  parameter int                ADDR_W       = 4,
  parameter logic [ADDR_W-1:0] ADDR_CMD     = 'hB,
  parameter logic [ADDR_W-1:0] ADDR_HUND    = 'hC,
  parameter logic [ADDR_W-1:0] ADDR_SEC     = 'hD,
  parameter int                PULSE_CYCLES = 600000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tod_hit,
  input  logic              tod_clr,
  output logic              int_a_n,
  output logic              int_b_n
);
  localparam int CNT_W = 4 * BCD_DIGITS;

  byte_t      hund_q, sec_q, hund_nx, sec_nx;
  logic [7:2] cmd_q;
  logic       hit_lo, hit_hi, hit_cmd;
  logic       wd_access, wd_hit, wd_flag, tod_flag;
  logic       cfg_zero;
  logic       cmd_swap, cmd_pulse, cmd_wmask, cmd_tmask;
  logic [CNT_W-1:0] cnt_q;

  assign hit_lo    = bus_cs && (bus_addr == ADDR_HUND);
  assign hit_hi    = bus_cs && (bus_addr == ADDR_SEC);
  assign hit_cmd   = bus_cs && (bus_addr == ADDR_CMD);
  assign wd_access = hit_lo || hit_hi;

  assign hund_nx = (hit_lo && bus_we) ? bus_wdata : hund_q;
  assign sec_nx  = (hit_hi && bus_we) ? bus_wdata : sec_q;
  assign cfg_zero = ~|{sec_q, hund_q};

  assign cmd_swap  = cmd_q[CMD_SWAP];
  assign cmd_pulse = cmd_q[CMD_PULSE];
  assign cmd_wmask = cmd_q[CMD_WMASK];
  assign cmd_tmask = cmd_q[CMD_TMASK];

  always_ff @(posedge clk) begin
    if (rst) begin
      hund_q <= '0;
      sec_q  <= '0;
      cmd_q  <= '0;
    end else begin
      hund_q <= hund_nx;
      sec_q  <= sec_nx;
      if (hit_cmd && bus_we) cmd_q <= bus_wdata[7:2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_cs && !bus_we) begin
      if (bus_addr == ADDR_HUND)     bus_rdata <= hund_q;
      else if (bus_addr == ADDR_SEC) bus_rdata <= sec_q;
      else if (bus_addr == ADDR_CMD) bus_rdata <= {cmd_q, wd_flag, tod_flag};
      else                           bus_rdata <= '0;
    end
  end

  wdt_bcd_down #(.DIGITS(BCD_DIGITS)) u_count (
    .clk        (clk),
    .rst        (rst),
    .load       (wd_access),
    .tick       (tick),
    .reload_val ({sec_nx, hund_nx}),
    .hit        (wd_hit),
    .count      (cnt_q)
  );

  wdt_alarm_latch #(.PULSE_CYCLES(PULSE_CYCLES)) u_wd_latch (
    .clk        (clk),
    .rst        (rst),
    .set        (wd_hit),
    .clr        (wd_access),
    .pulse_mode (cmd_pulse),
    .flag       (wd_flag)
  );

  wdt_alarm_latch #(.PULSE_CYCLES(PULSE_CYCLES)) u_tod_latch (
    .clk        (clk),
    .rst        (rst),
    .set        (tod_hit),
    .clr        (tod_clr),
    .pulse_mode (cmd_pulse),
    .flag       (tod_flag)
  );

  wdt_irq_route u_route (
    .clk     (clk),
    .rst     (rst),
    .wd_act  (wd_flag && !cmd_wmask),
    .tod_act (tod_flag && !cmd_tmask),
    .swap    (cmd_swap),
    .int_a_n (int_a_n),
    .int_b_n (int_b_n)
  );
endmodule

// File: rtl/wdt_bcd_chk.sv
module wdt_bcd_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wd_access,
  input logic             wd_flag,
  input logic             cfg_zero,
  input logic             swap,
  input logic             wd_mask,
  input logic             pulse,
  input logic [CNT_W-1:0] cnt,
  input logic             int_a_n
);
  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wd_access |=> !wd_flag); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_zero |=> !$rose(wd_flag)); // R6

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!swap && wd_mask) |=> int_a_n); // R8

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pulse && wd_flag && !wd_access) |=> wd_flag); // R11

  generate
    for (genvar d = 0; d < CNT_W / 4; d++) begin : g_bcd
      AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (rst)
        cnt[4*d +: 4] <= 4'd9); // R2
    end
  endgenerate
endmodule

bind wdt_bcd_top wdt_bcd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wd_access (wd_access),
  .wd_flag   (wd_flag),
  .cfg_zero  (cfg_zero),
  .swap      (cmd_swap),
  .wd_mask   (cmd_wmask),
  .pulse     (cmd_pulse),
  .cnt       (cnt_q),
  .int_a_n   (int_a_n)
);

// File: tb/wdt_bcd_top_tb_top.sv
`timescale 1ns/1ps
module wdt_bcd_top_tb_top;
  localparam int PULSE = 6;

  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic       bus_cs = 1'b0, bus_we = 1'b0, tod_hit = 1'b0, tod_clr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       int_a_n, int_b_n;
  int checks = 0, errors = 0;
  logic [7:0] rv;
  int n;

  always #2.5 clk = ~clk;

  wdt_bcd_top #(.PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tod_hit(tod_hit), .tod_clr(tod_clr), .int_a_n(int_a_n), .int_b_n(int_b_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_cs = 0; d = bus_rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  task automatic strobe_tod(input bit clr);
    @(negedge clk); if (clr) tod_clr = 1; else tod_hit = 1;
    @(negedge clk); tod_clr = 0; tod_hit = 0;
    @(negedge clk);
  endtask

  // ticks until int_a_n falls; limit+1 when it never does
  task automatic ticks_to_alarm(input int limit, output int cnt);
    cnt = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      do_tick();
      if (!int_a_n) begin cnt = i; break; end
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic set_period(input int secs, input int hund);
    wr(4'hC, to_bcd(hund));
    wr(4'hD, to_bcd(secs));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog timeout actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12 int_a_n", int_a_n, 1);
    chk("R12 int_b_n", int_b_n, 1);
    rd(4'hC, rv); chk("R12 reg C", rv, 0);
    rd(4'hD, rv); chk("R12 reg D", rv, 0);
    rd(4'hB, rv); chk("R12 reg B", rv, 0);

    // R1 readback
    wr(4'hC, 8'h37); wr(4'hD, 8'h42);
    rd(4'hC, rv); chk("R1 reg C", rv, 'h37);
    rd(4'hD, rv); chk("R1 reg D", rv, 'h42);

    // R2 sweep of hundredths 1..25, level mode, watchdog on pin A
    wr(4'hB, 8'h00);
    for (int h = 1; h <= 25; h++) begin
      set_period(0, h);
      ticks_to_alarm(30, n);
      chk("R2 sweep", n, h);
    end
    // R2 borrow boundaries and full range
    set_period(1, 0);   ticks_to_alarm(200, n);   chk("R2 01.00", n, 100);
    set_period(1, 1);   ticks_to_alarm(200, n);   chk("R2 01.01", n, 101);
    set_period(10, 0);  ticks_to_alarm(1100, n);  chk("R2 10.00", n, 1000);
    set_period(99, 99); ticks_to_alarm(10100, n); chk("R2 99.99", n, 9999);

    // R11 level hold across reloads, R7 flag read
    set_period(0, 3);
    ticks_to_alarm(10, n); chk("R11 first", n, 3);
    for (int i = 0; i < 7; i++) do_tick();
    chk("R11 still low", int_a_n, 0);
    rd(4'hB, rv); chk("R7 flag bit1", rv, 'h02);

    // R4 read access clears and restarts
    rd(4'hC, rv); @(negedge clk);
    chk("R4 cleared by read", int_a_n, 1);
    ticks_to_alarm(10, n); chk("R4 restart", n, 3);
    wr(4'hD, 8'h00); @(negedge clk);
    chk("R4 cleared by write", int_a_n, 1);
    do_tick(); do_tick();
    rd(4'hD, rv);
    ticks_to_alarm(10, n); chk("R4 partial restart", n, 3);

    // R5 single-register writes
    wr(4'hC, 8'h05); wr(4'hD, 8'h01);
    ticks_to_alarm(200, n); chk("R5 write D only", n, 105);
    wr(4'hC, 8'h00);
    ticks_to_alarm(200, n); chk("R5 write C only", n, 100);

    // R6 disabled
    set_period(0, 0);
    ticks_to_alarm(60, n); chk("R6 disabled", n, 61);
    rd(4'hB, rv); chk("R6 no flag", rv, 0);

    // R7 flag bits ignore writes
    wr(4'hB, 8'hA7);
    rd(4'hB, rv); chk("R7 ro bits", rv, 'hA4);

    // R8 mask
    wr(4'hB, 8'h08);
    set_period(0, 2);
    do_tick(); do_tick();
    chk("R8 pin A masked", int_a_n, 1);
    chk("R8 pin B idle", int_b_n, 1);
    rd(4'hB, rv); chk("R8 flag set", rv, 'h0A);
    wr(4'hB, 8'h04);
    strobe_tod(0);
    chk("R8 tod masked", int_b_n, 1);
    strobe_tod(1);

    // R9 swap
    wr(4'hB, 8'h00); set_period(0, 1);
    strobe_tod(0);
    chk("R9 swap0 tod on B", int_b_n, 0);
    chk("R9 swap0 A idle", int_a_n, 1);
    do_tick();
    chk("R9 swap0 wd on A", int_a_n, 0);
    strobe_tod(1); rd(4'hC, rv);
    wr(4'hB, 8'h40);
    strobe_tod(0);
    chk("R9 swap1 tod on A", int_a_n, 0);
    chk("R9 swap1 B idle", int_b_n, 1);
    do_tick();
    chk("R9 swap1 wd on B", int_b_n, 0);
    rd(4'hB, rv); chk("R9 both flags", rv, 'h43);
    strobe_tod(1); rd(4'hC, rv);

    // R10 pulse width, R3 repeat
    wr(4'hB, 8'h10); set_period(0, 2);
    do_tick(); do_tick();
    n = 0;
    while (!int_a_n && n < 50) begin n++; @(negedge clk); end
    chk("R10 pulse width", n, PULSE);
    rd(4'hB, rv); chk("R10 flag cleared", rv, 'h10);
    ticks_to_alarm(10, n); chk("R3 repeat", n, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule